// File: doc/BRIEF.md
# Glitch-Free N-Way Clock Selector

This block picks one of several free-running clock sources and drives it onto a single output clock, with no runt pulse or chopped phase while the choice changes. The sources may run at unrelated frequencies and phases. A binary index chooses the wanted source. Each source has a small enable chain that runs entirely in that source's own clock domain. The chain first passes the request through one or more rising-edge stages, which resolve metastability. A falling-edge register then opens or closes that source's gate.

A source may ask for its gate only while every other source's gate is shut. A change of selection therefore always closes the old gate first, on a falling edge of the old clock. The new gate opens later, on a falling edge of the new clock. Between the two, the output rests low.

The per-source gate states are brought out as a status vector. Software-free logic, such as a clock controller, can watch it to see when a switch has completed. The active-low reset shuts every gate. A source that never starts therefore cannot hold up a switch to any other source.

Top module: `glitchless_clk_sel`

## Requirements
- R1: Bit k of `en_o` belongs to source k, which `sel_i` selects with the binary value k. While `sel_i` is held at k and source k runs, `en_o` settles to the value with only bit k set. `clk_o` then repeats source k's period.
- R2: While `rst_n_i` is low, `en_o` is all zero and `clk_o` stays low without edges.
- R3: `en_o` never has more than one bit set.
- R4: Each enable bit changes only while its own source clock is low. As a result, no high or low phase of `clk_o` is shorter than the shortest half period among the sources.
- R5: A `sel_i` value of NUM_SRC or greater clears every enable once it has passed the synchronizer stages. `clk_o` then stays low.
- R6: Take a halted source whose enable is clear. It does not stop switching among the running sources, including across a reset. Selecting that halted source leaves `en_o` all zero and `clk_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src_i | input | NUM_SRC | Source clocks, bit k is source k |
| rst_n_i | input | 1 | Active-low reset, asserted asynchronously, released per domain |
| sel_i | input | SEL_W | Binary index of the wanted source |
| clk_o | output | 1 | Switched output clock |
| en_o | output | NUM_SRC | Gate state per source, at most one bit set |

## Verification
On every change of the gate vector, the bound checker confirms that at most one gate is open. It also confirms that each gate opens or closes only while its own source is low. A per-domain counter lets it prove that a held out-of-range index drains every gate.

Other behaviour shows only over a whole switch, so the bench's scenarios cover it. The output period must match the chosen source once settled. No short phase may appear on the output across randomly ordered switches between sources of unrelated period. A stopped source must not hold up switching, and selecting it must leave the output quiet.

// File: rtl/gcs_pkg.sv
// Package: shared constants and helpers for the glitch-free clock selector.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package gcs_pkg;

    // Smallest legal number of sources.
    localparam int unsigned GCS_MIN_SRC = 2;

    // Default count of rising-edge stages ahead of the falling-edge gate.
    localparam int unsigned GCS_DEF_SYNC = 1;

    // Width of a binary index able to name n sources.
    function automatic int unsigned gcs_idx_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/gcs_sel_decode.sv
// Module: turns the binary source index into a one-hot request vector.
// An index of NUM_SRC or more yields an all-zero vector.
// Assumes the index is quasi-static; each bit is synchronized later per domain.
module gcs_sel_decode #(
    parameter int unsigned NUM_SRC = 3,
    parameter int unsigned SEL_W   = 2
) (
    input  logic [SEL_W-1:0]   sel_i,
    output logic [NUM_SRC-1:0] onehot_o
);

    // Compare the index against every legal source number.
    always_comb begin
        onehot_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel_i == SEL_W'(i)) onehot_o[i] = 1'b1;
        end
    end

endmodule

// File: rtl/gcs_rst_sync.sv
// Module: reset conditioner for one source domain.
// It asserts at once with the raw reset and releases on a rising edge of that domain.
// Assumes the raw reset is active low; a halted clock keeps the domain in reset.
module gcs_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    output logic rst_n_o
);

    logic [STAGES-1:0] shift_q;

    // Shift ones in after release; clear everything on reset.
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) shift_q <= '0;
        else          shift_q <= {shift_q[STAGES-2:0], 1'b1};
    end

    assign rst_n_o = shift_q[STAGES-1];

endmodule

// File: rtl/gcs_src_chain.sv
// Module: enable chain of one source.
// The chain has SYNC_STAGES rising-edge flops, then a falling-edge gate flop.
// All of them are clocked by this source only.
// Assumes req_i may change at any time relative to clk_i.
module gcs_src_chain #(
    parameter int unsigned SYNC_STAGES = 1
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic req_i,
    output logic en_o
);

    logic                 dom_rst_n;
    logic [SYNC_STAGES:0] pipe;

    gcs_rst_sync #(.STAGES(2)) i_rst_sync (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .rst_n_o (dom_rst_n)
    );

    assign pipe[0] = req_i;

    for (genvar s = 1; s <= SYNC_STAGES; s++) begin : g_stage
        // Rising-edge stage s: lets a metastable sample settle.
        always_ff @(posedge clk_i or negedge dom_rst_n) begin
            if (!dom_rst_n) pipe[s] <= 1'b0;
            else            pipe[s] <= pipe[s-1];
        end
    end

    // Gate flop: changes only as the clock falls, so no phase is cut.
    always_ff @(negedge clk_i or negedge dom_rst_n) begin
        if (!dom_rst_n) en_o <= 1'b0;
        else            en_o <= pipe[SYNC_STAGES];
    end

endmodule

// File: rtl/gcs_clk_merge.sv
// Module: AND-OR combiner; each source is ANDed with its gate and the results ORed.
// Assumes the gates are mutually exclusive and change only while their clock is low.
module gcs_clk_merge #(
    parameter int unsigned NUM_SRC = 3
) (
    input  logic [NUM_SRC-1:0] clk_src_i,
    input  logic [NUM_SRC-1:0] en_i,
    output logic               clk_o
);

    // Merge all gated sources into the single output.
    always_comb begin
        clk_o = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            clk_o = clk_o | (clk_src_i[i] & en_i[i]);
        end
    end

endmodule

// File: rtl/glitchless_clk_sel.sv
// Module: top of the glitch-free N-way clock selector.
// Each source gets a request only while every other gate is closed.
// This gives break-before-make between any pair of sources.
// Assumes sel_i is held until en_o shows the new source, or all zero.
module glitchless_clk_sel #(
    parameter int unsigned NUM_SRC     = 3,
    parameter int unsigned SYNC_STAGES = gcs_pkg::GCS_DEF_SYNC,
    parameter int unsigned SEL_W       = gcs_pkg::gcs_idx_width(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] clk_src_i,
    input  logic               rst_n_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               clk_o,
    output logic [NUM_SRC-1:0] en_o
);

    logic [NUM_SRC-1:0] want;
    logic [NUM_SRC-1:0] req;
    logic [NUM_SRC-1:0] en_w;

    gcs_sel_decode #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) i_decode (
        .sel_i    (sel_i),
        .onehot_o (want)
    );

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        localparam logic [NUM_SRC-1:0] OTHERS = ~(NUM_SRC'(1) << k);

        // Request: wanted and every other gate closed.
        assign req[k] = want[k] & ~(|(en_w & OTHERS));

        gcs_src_chain #(.SYNC_STAGES(SYNC_STAGES)) i_chain (
            .clk_i   (clk_src_i[k]),
            .rst_n_i (rst_n_i),
            .req_i   (req[k]),
            .en_o    (en_w[k])
        );
    end

    gcs_clk_merge #(.NUM_SRC(NUM_SRC)) i_merge (
        .clk_src_i (clk_src_i),
        .en_i      (en_w),
        .clk_o     (clk_o)
    );

    assign en_o = en_w;

endmodule

// File: rtl/gcs_checker.sv
// Module: assertion checker bound to glitchless_clk_sel.
// Assumes the same parameters as the bound instance.
module gcs_checker #(
    parameter int unsigned NUM_SRC     = 3,
    parameter int unsigned SYNC_STAGES = 1,
    parameter int unsigned SEL_W       = 2
) (
    input logic [NUM_SRC-1:0] clk_src_i,
    input logic               rst_n_i,
    input logic [SEL_W-1:0]   sel_i,
    input logic [NUM_SRC-1:0] en_o
);

    localparam int unsigned DRAIN = SYNC_STAGES + 1;

    // At most one open gate at any moment.
    always_comb begin
        if (rst_n_i) begin
            assert_single_gate_R3: assert ($onehot0(en_o))
                else $error("R3: en_o=%b", en_o);
        end
    end

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_chk
        logic [7:0] oor_cnt;

        // Gate opens only while its source is low.
        always @(posedge en_o[k]) begin
            if (rst_n_i) begin
                assert_open_low_R4: assert (clk_src_i[k] == 1'b0)
                    else $error("R4: gate %0d opened while high", k);
            end
        end

        // Gate closes only while its source is low.
        always @(negedge en_o[k]) begin
            if (rst_n_i) begin
                assert_close_low_R4: assert (clk_src_i[k] == 1'b0)
                    else $error("R4: gate %0d closed while high", k);
            end
        end

        // Count consecutive edges of this source that saw an out-of-range index.
        always_ff @(posedge clk_src_i[k] or negedge rst_n_i) begin
            if (!rst_n_i)                oor_cnt <= '0;
            else if (sel_i < NUM_SRC)    oor_cnt <= '0;
            else if (oor_cnt != 8'hFF)   oor_cnt <= oor_cnt + 8'd1;
        end

        assert_oor_drain_R5: assert property (
            @(posedge clk_src_i[k]) disable iff (!rst_n_i)
            (oor_cnt >= 8'(DRAIN)) |-> !en_o[k]
        ) else $error("R5: gate %0d open on out-of-range index", k);
    end

endmodule

bind glitchless_clk_sel gcs_checker #(
    .NUM_SRC     (NUM_SRC),
    .SYNC_STAGES (SYNC_STAGES),
    .SEL_W       (SEL_W)
) i_gcs_checker (
    .clk_src_i (clk_src_i),
    .rst_n_i   (rst_n_i),
    .sel_i     (sel_i),
    .en_o      (en_o)
);

// File: tb/test_glitchless_clk_sel.sv
`timescale 1ns/100ps
module test_glitchless_clk_sel;

    localparam int NSRC       = 3;
    localparam int SW         = 2;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 1000000;

    logic [NSRC-1:0] src_clk;
    logic [NSRC-1:0] run = '1;
    logic            rst_n = 1'b0;
    logic [SW-1:0]   sel = '0;
    logic            clk_o;
    logic [NSRC-1:0] en_o;

    int n_chk = 0;
    int n_bad = 0;
    int edge_cnt = 0;
    int runt_cnt = 0;
    bit mon_on = 0;
    bit have_last = 0;
    realtime last_t;

    // Source period in ns; unrelated values.
    function automatic int exp_period(input int k);
        return (k == 0) ? CLK_PERIOD : (k == 1) ? CLK_PERIOD + 4 : 2 * CLK_PERIOD + 2;
    endfunction

    // Expected gate vector for an index.
    function automatic logic [NSRC-1:0] exp_gate(input int idx);
        return (idx < NSRC) ? NSRC'(1) << idx : '0;
    endfunction

    for (genvar k = 0; k < NSRC; k++) begin : g_clk
        logic c = 1'b0;
        // Free-running source; a halted one parks low.
        always begin
            #(exp_period(k) / 2);
            if (run[k] || c) c = ~c;
        end
        assign src_clk[k] = c;
    end

    glitchless_clk_sel #(.NUM_SRC(NSRC)) i_glitchless_clk_sel (
        .clk_src_i (src_clk),
        .rst_n_i   (rst_n),
        .sel_i     (sel),
        .clk_o     (clk_o),
        .en_o      (en_o)
    );

    // Count rising output edges.
    always @(posedge clk_o) edge_cnt++;

    // Flag any output phase shorter than the shortest source half period.
    always @(clk_o) begin
        if (mon_on) begin
            if (have_last && ($realtime - last_t) < (CLK_PERIOD / 2) - 0.01) runt_cnt++;
            have_last = 1;
            last_t = $realtime;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_gate(input logic [NSRC-1:0] exp);
        for (int i = 0; i < 1500; i++) begin
            if (en_o == exp) break;
            #1;
        end
    endtask

    task automatic measure(input int idx, input string req);
        realtime t0, t1;
        @(posedge clk_o); t0 = $realtime;
        @(posedge clk_o); t1 = $realtime;
        check(((t1 - t0) > exp_period(idx) - 0.01) && ((t1 - t0) < exp_period(idx) + 0.01),
              req, longint'(t1 - t0), exp_period(idx));
        #0.3;
    endtask

    task automatic switch_to(input int idx, input string req);
        sel = SW'(idx);
        wait_gate(exp_gate(idx));
        check(en_o == exp_gate(idx), req, en_o, exp_gate(idx));
        measure(idx, req);
    endtask

    task automatic quiet_check(input string req);
        int e0;
        #300;
        check(en_o == '0, req, en_o, 0);
        e0 = edge_cnt;
        #200;
        check(edge_cnt == e0, req, edge_cnt - e0, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        #50.3;
        // R2: reset holds every gate shut
        check(en_o == '0, "R2", en_o, 0);
        check(clk_o == 1'b0, "R2", clk_o, 0);
        check(edge_cnt == 0, "R2", edge_cnt, 0);
        rst_n = 1'b1;
        mon_on = 1;
        switch_to(0, "R1");
        // R1/R4: random switches among running sources
        for (int n = 0; n < 24; n++) begin
            switch_to(int'($urandom_range(0, NSRC - 1)), "R1");
            check(runt_cnt == 0, "R4", runt_cnt, 0);
        end
        // R5: out-of-range index drains all gates
        sel = SW'(3);
        quiet_check("R5");
        switch_to(1, "R1");
        // R6: halt source 2 and keep switching among the others
        run[2] = 1'b0;
        #50;
        switch_to(0, "R6");
        switch_to(1, "R6");
        sel = SW'(2);
        quiet_check("R6");
        switch_to(0, "R6");
        // R6/R2: reset with a halted source, then select a running one
        mon_on = 0;
        have_last = 0;
        rst_n = 1'b0;
        #30;
        check(en_o == '0, "R2", en_o, 0);
        rst_n = 1'b1;
        mon_on = 1;
        switch_to(1, "R6");
        check(runt_cnt == 0, "R4", runt_cnt, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(WATCHDOG);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule